// File: doc/BRIEF.md
# DRAM Multipurpose Register Page-0 Write and Readout

This block is the device-side model of the DRAM's multipurpose register access mode. It observes decoded commands (mode-register set, activate, precharge-all, write) and keeps track of whether multipurpose data flow is switched on and which page is selected. While the mode is on and page zero is selected, a write command does not reach the array. Its payload comes from address bits [7:0] and is stored in one of four byte registers, chosen by the bank address.

A separate read port streams a chosen register as an eight-beat serial burst in fixed ascending bit order. Three situations raise a one-cycle error pulse, and none of them changes any state:

- entering the mode while a bank is open;
- writing when a page other than zero is selected;
- issuing any command before a programmable mode-register settle time has elapsed after entry.

Top module: `mpr_page0_top`

## Requirements
- R1: After reset `mprActive` is 0, `pageSel` is 0, no error is high and `rdValid` is 0. The four registers hold 8'h55, 8'h33, 8'h0F and 8'h00 for selections 0, 1, 2 and 3.
- R2: Command codes are 0 idle, 1 mode-register set, 2 activate, 3 precharge-all, 4 write, 5 write with auto-precharge, 6 and 7 other. A mode-register set with `ba` = 2'b11 and `addr[2]` = 1 switches the mode on with page `addr[1:0]`. The same command with `addr[2]` = 0 switches it off. A mode-register set with any other `ba` value has no effect on the mode.
- R3: Activate marks bank `ba` open, and precharge-all closes every bank. A request to switch the mode on while any bank is open pulses `errOpenBank` one cycle later and leaves the mode and page unchanged.
- R4: After the mode is switched on, every non-idle command in the next `tModCycles` cycles pulses `errTiming` one cycle later and has no effect. With `tModCycles` = 0, the cycle right after entry is already open for commands.
- R5: While the mode is on with page 0, a write or write with auto-precharge stores `addr[7:0]` into register `ba`.
- R6: While the mode is on with a nonzero page, a write pulses `errPage` one cycle later and changes no register.
- R7: A write while the mode is off changes no register.
- R8: A one-cycle `rdReq` with `rdSel` = k drives `rdValid` high for exactly 8 cycles, starting the cycle after the request. In beat n (n = 0..7), `rdBit` carries bit n of register k.
- R9: A read request made while a burst is in progress is ignored.
- R10: Stored values survive leaving and re-entering the mode. Only reset restores the default values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdCode | input | 3 | Decoded command, encoding per R2 |
| ba | input | 2 | Bank address; selects the mode register or the byte register |
| addr | input | ADDR_W | Address bus; [2] is the mode enable, [1:0] the page, [7:0] the write data |
| tModCycles | input | TMOD_W | Settle window after mode entry, in cycles |
| rdReq | input | 1 | Start a serial readout |
| rdSel | input | 2 | Register to read out |
| mprActive | output | 1 | Mode is on |
| pageSel | output | 2 | Selected page |
| errOpenBank | output | 1 | Entry refused, a bank is open |
| errPage | output | 1 | Write refused, a nonzero page is selected |
| errTiming | output | 1 | Command refused inside the settle window |
| rdValid | output | 1 | Burst beat valid |
| rdBit | output | 1 | Burst data bit |

## Verification
The hardest situation to reach from the ports is a write that lands while the mode is on, a nonzero page is selected and the settle window has expired. Reaching it requires, in order, all banks closed, a successful entry with the page bits set, and enough idle or rejected cycles to drain the counter. Random stimulus reaches it only rarely. Directed sequences therefore build the exact order (precharge-all, entry with page 2, counted idles, write). The random phase biases entries toward page 0 and issues precharge-all often, so that settle-window collisions and accepted writes both occur in volume. Each cycle of the random phase is compared against a cycle-accurate bench model.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MRS  = 3'd1,
    CMD_ACT  = 3'd2,
    CMD_PREA = 3'd3,
    CMD_WR   = 3'd4,
    CMD_WRA  = 3'd5,
    CMD_RD   = 3'd6,
    CMD_OTH  = 3'd7
  } cmd_e;

  localparam int MPR_W     = 8;
  localparam int MPR_NUM   = 4;
  localparam int SEL_W     = $clog2(MPR_NUM);
  localparam logic [1:0] MR_MPR = 2'b11;

  typedef struct packed {
    logic             wrEn;
    logic [SEL_W-1:0] wrSel;
    logic [MPR_W-1:0] wrData;
  } mprStrobe_t;
endpackage

// File: rtl/mpr_ctrl.sv
module mpr_ctrl
  import mpr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int TMOD_W = 6,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdCode,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TMOD_W-1:0] tModCycles,
  output mprStrobe_t        strobe,
  output logic              mprActive,
  output logic [1:0]        pageSel,
  output logic              errOpenBank,
  output logic              errPage,
  output logic              errTiming
);
  localparam int NUM_BANKS = 1 << BA_W;

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] bankOpen;
  logic [TMOD_W-1:0]    modCnt;
  logic                 gated, isMr3, enterReq, enterOk, isWr, anyOpen;

  assign cmd = cmd_e'(cmdCode);

  always_comb begin
    anyOpen  = |bankOpen;
    gated    = (cmd != CMD_NOP) && (modCnt != '0);
    isMr3    = !gated && (cmd == CMD_MRS) && (ba[1:0] == MR_MPR);
    enterReq = isMr3 && addr[2];
    enterOk  = enterReq && !anyOpen;
    isWr     = !gated && mprActive && ((cmd == CMD_WR) || (cmd == CMD_WRA));
    strobe.wrEn   = isWr && (pageSel == 2'b00);
    strobe.wrSel  = ba[SEL_W-1:0];
    strobe.wrData = addr[MPR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mprActive   <= 1'b0;
      pageSel     <= 2'b00;
      bankOpen    <= '0;
      modCnt      <= '0;
      errOpenBank <= 1'b0;
      errPage     <= 1'b0;
      errTiming   <= 1'b0;
    end else begin
      errTiming   <= gated;
      errOpenBank <= enterReq && anyOpen;
      errPage     <= isWr && (pageSel != 2'b00);
      if (isMr3) begin
        if (!addr[2]) begin
          mprActive <= 1'b0;
        end else if (enterOk) begin
          mprActive <= 1'b1;
          pageSel   <= addr[1:0];
        end
      end
      if (!gated) begin
        if (cmd == CMD_ACT) bankOpen[ba] <= 1'b1;
        else if (cmd == CMD_PREA) bankOpen <= '0;
      end
      if (enterOk) modCnt <= tModCycles;
      else if (modCnt != '0) modCnt <= modCnt - 1'b1;
    end
  end
endmodule

// File: rtl/mpr_datapath.sv
module mpr_datapath
  import mpr_pkg::*;
#(
  parameter logic [MPR_NUM*MPR_W-1:0] RESET_PATTERN = 32'h000F_3355
) (
  input  logic             clk,
  input  logic             rstN,
  input  mprStrobe_t       strobe,
  input  logic             rdReq,
  input  logic [SEL_W-1:0] rdSel,
  output logic             rdValid,
  output logic             rdBit
);
  localparam int BEAT_W = $clog2(MPR_W);

  logic [MPR_W-1:0]  mprReg [MPR_NUM];
  logic [MPR_W-1:0]  shiftReg;
  logic [BEAT_W-1:0] beatsLeft;

  for (genvar i = 0; i < MPR_NUM; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mprReg[i] <= RESET_PATTERN[i*MPR_W +: MPR_W];
      else if (strobe.wrEn && (strobe.wrSel == SEL_W'(i))) mprReg[i] <= strobe.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      shiftReg  <= '0;
      beatsLeft <= '0;
    end else if (rdValid) begin
      if (beatsLeft == '0) begin
        rdValid <= 1'b0;
      end else begin
        shiftReg  <= shiftReg >> 1;
        beatsLeft <= beatsLeft - 1'b1;
      end
    end else if (rdReq) begin
      rdValid   <= 1'b1;
      shiftReg  <= mprReg[rdSel];
      beatsLeft <= BEAT_W'(MPR_W - 1);
    end
  end

  assign rdBit = rdValid & shiftReg[0];
endmodule

// File: rtl/mpr_page0_top.sv
module mpr_page0_top
  import mpr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int TMOD_W = 6,
  parameter logic [31:0] RESET_PATTERN = 32'h000F_3355
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdCode,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TMOD_W-1:0] tModCycles,
  input  logic              rdReq,
  input  logic [1:0]        rdSel,
  output logic              mprActive,
  output logic [1:0]        pageSel,
  output logic              errOpenBank,
  output logic              errPage,
  output logic              errTiming,
  output logic              rdValid,
  output logic              rdBit
);
  mprStrobe_t strobe;

  mpr_ctrl #(.ADDR_W(ADDR_W), .TMOD_W(TMOD_W), .BA_W(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .ba(ba), .addr(addr),
    .tModCycles(tModCycles), .strobe(strobe), .mprActive(mprActive),
    .pageSel(pageSel), .errOpenBank(errOpenBank), .errPage(errPage),
    .errTiming(errTiming)
  );

  mpr_datapath #(.RESET_PATTERN(RESET_PATTERN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdReq(rdReq), .rdSel(rdSel),
    .rdValid(rdValid), .rdBit(rdBit)
  );
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       mprActive,
  input logic [1:0] pageSel,
  input logic       errOpenBank,
  input logic       errPage,
  input logic       errTiming,
  input logic       rdValid
);
  logic [4:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (rdValid) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (!mprActive && pageSel == 2'b00 && !rdValid));

  assert_open_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    errOpenBank |-> ($stable(mprActive) && $stable(pageSel)));

  assert_settle_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    errTiming |-> ($stable(mprActive) && $stable(pageSel)));

  assert_single_error_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errOpenBank, errPage, errTiming}));

  assert_page_reject_R6: assert property (@(posedge clk) disable iff (!rstN)
    errPage |-> (mprActive && pageSel != 2'b00));

  assert_burst_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdValid) |-> (runLen == 5'd8));
endmodule

bind mpr_page0_top mpr_checker u_chk (
  .clk(clk), .rstN(rstN), .mprActive(mprActive), .pageSel(pageSel),
  .errOpenBank(errOpenBank), .errPage(errPage), .errTiming(errTiming),
  .rdValid(rdValid)
);

// File: tb/sim_mpr_page0_top.sv
`timescale 1ns/1ps
module sim_mpr_page0_top;
  localparam int ADDR_W = 14;
  localparam int TMOD_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [1:0] ba = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic [TMOD_W-1:0] tModCycles = 6'd3;
  logic rdReq = 1'b0;
  logic [1:0] rdSel = 2'd0;
  logic mprActive, errOpenBank, errPage, errTiming, rdValid, rdBit;
  logic [1:0] pageSel;

  int checks = 0;
  int fails = 0;

  logic [7:0] mReg [4];
  logic       mAct;
  logic [1:0] mPage;
  logic [3:0] mOpen;
  int         mCnt;

  always #5 clk = ~clk;

  mpr_page0_top #(.ADDR_W(ADDR_W), .TMOD_W(TMOD_W)) u0 (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .ba(ba), .addr(addr),
    .tModCycles(tModCycles), .rdReq(rdReq), .rdSel(rdSel),
    .mprActive(mprActive), .pageSel(pageSel), .errOpenBank(errOpenBank),
    .errPage(errPage), .errTiming(errTiming), .rdValid(rdValid), .rdBit(rdBit)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mReg[0] = 8'h55; mReg[1] = 8'h33; mReg[2] = 8'h0F; mReg[3] = 8'h00;
    mAct = 1'b0; mPage = 2'b00; mOpen = 4'h0; mCnt = 0;
  endtask

  // One clock: drive at negedge, predict, sample 1 ns after the edge.
  task automatic cycle(input logic [2:0] c, input logic [1:0] b, input logic [ADDR_W-1:0] a,
                       input bit rq, input logic [1:0] rs);
    bit eT, eO, eP, loaded;
    @(negedge clk);
    cmdCode = c; ba = b; addr = a; rdReq = rq; rdSel = rs;
    eT = 0; eO = 0; eP = 0; loaded = 0;
    if (mCnt != 0 && c != 3'd0) eT = 1;
    else begin
      case (c)
        3'd1: if (b == 2'b11) begin
                if (a[2]) begin
                  if (mOpen != 0) eO = 1;
                  else begin mAct = 1; mPage = a[1:0]; mCnt = int'(tModCycles); loaded = 1; end
                end else mAct = 0;
              end
        3'd2: mOpen[b] = 1'b1;
        3'd3: mOpen = 4'h0;
        3'd4, 3'd5: if (mAct) begin
                if (mPage == 2'b00) mReg[b] = a[7:0];
                else eP = 1;
              end
        default: ;
      endcase
    end
    if (!loaded && mCnt != 0) mCnt--;
    @(posedge clk); #1;
    chk(errTiming == eT, "R4 errTiming", errTiming, eT);
    chk(errOpenBank == eO, "R3 errOpenBank", errOpenBank, eO);
    chk(errPage == eP, "R6 errPage", errPage, eP);
    chk(mprActive == mAct, "R2 mprActive", mprActive, mAct);
    chk(pageSel == mPage, "R2 pageSel", pageSel, mPage);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(3'd0, 2'd0, '0, 0, 2'd0);
  endtask

  // Serial readout; with poke set, a second request is made mid-burst (R9).
  task automatic readCheck(input logic [1:0] sel, input bit poke, input string req);
    logic [7:0] got;
    bit allValid;
    allValid = 1;
    cycle(3'd0, 2'd0, '0, 1, sel);
    got[0] = rdBit; allValid &= rdValid;
    for (int n = 1; n < 8; n++) begin
      cycle(3'd0, 2'd0, '0, poke && n == 3, sel + 2'd1);
      got[n] = rdBit; allValid &= rdValid;
    end
    chk(allValid, {req, " R8 rdValid beats"}, allValid, 1);
    chk(got == mReg[sel], {req, " R8 burst data"}, got, mReg[sel]);
    cycle(3'd0, 2'd0, '0, 0, 2'd0);
    chk(rdValid == 1'b0, {req, " R8/R9 burst end"}, rdValid, 0);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; cmdCode = 3'd0; rdReq = 1'b0;
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    chk(!mprActive && pageSel == 0 && !errOpenBank && !errPage && !errTiming && !rdValid,
        "R1 reset outputs", {mprActive, pageSel, rdValid}, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    for (int k = 0; k < 4; k++) readCheck(2'(k), 0, "R1 defaults");

    // R7: write with mode off
    cycle(3'd4, 2'd1, 14'h0AA, 0, 0);
    readCheck(2'd1, 0, "R7 write ignored");

    // R2: other mode register
    cycle(3'd1, 2'd1, 14'h004, 0, 0);
    chk(!mprActive, "R2 other MR no entry", mprActive, 0);

    // R3: open bank blocks entry
    cycle(3'd2, 2'd2, '0, 0, 0);
    cycle(3'd1, 2'd3, 14'h004, 0, 0);
    chk(!mprActive, "R3 entry refused", mprActive, 0);
    cycle(3'd3, 2'd0, '0, 0, 0);

    // R4: settle window of 3, then R5 write
    tModCycles = 6'd3;
    cycle(3'd1, 2'd3, 14'h004, 0, 0);
    cycle(3'd4, 2'd2, 14'h0C3, 0, 0);
    cycle(3'd0, 2'd0, '0, 0, 0);
    cycle(3'd5, 2'd0, 14'h011, 0, 0);
    cycle(3'd4, 2'd2, 14'h0C3, 0, 0);
    cycle(3'd5, 2'd0, 14'h1A7, 0, 0);
    readCheck(2'd2, 0, "R5 write MPR2");
    readCheck(2'd0, 1, "R9 poke during burst");

    // R6: page 2 rejects writes
    cycle(3'd1, 2'd3, 14'h006, 0, 0);
    idle(3);
    cycle(3'd4, 2'd3, 14'h0EE, 0, 0);
    readCheck(2'd3, 0, "R6 page reject");

    // R4 boundary: zero window, exit and re-entry keep data (R10)
    tModCycles = 6'd0;
    cycle(3'd1, 2'd3, 14'h000, 0, 0);
    cycle(3'd1, 2'd3, 14'h004, 0, 0);
    cycle(3'd4, 2'd3, 14'h05A, 0, 0);
    cycle(3'd1, 2'd3, 14'h000, 0, 0);
    cycle(3'd1, 2'd3, 14'h004, 0, 0);
    readCheck(2'd3, 0, "R10 persist");
    readCheck(2'd2, 0, "R10 persist");

    // Random phase
    tModCycles = 6'd2;
    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [2:0] c;
      logic [1:0] b;
      logic [ADDR_W-1:0] a;
      r = int'($urandom % 16);
      b = 2'($urandom);
      a = ADDR_W'($urandom);
      if (r < 4) c = 3'd0;
      else if (r < 6) begin
        c = 3'd1;
        if ($urandom % 4 != 0) b = 2'b11;
        if ($urandom % 2 != 0) a[1:0] = 2'b00;
        if ($urandom % 4 != 0) a[2] = 1'b1;
      end
      else if (r == 6) c = 3'd2;
      else if (r < 9) c = 3'd3;
      else if (r < 14) c = 3'd4;
      else if (r == 14) c = 3'd5;
      else c = 3'd6;
      cycle(c, b, a, 0, 0);
      if (i % 300 == 299) begin
        idle(3);
        readCheck(2'($urandom), 0, "R5 random");
      end
    end
    idle(3);
    for (int k = 0; k < 4; k++) readCheck(2'(k), 0, "R5/R10 random final");

    // R10: reset restores defaults
    applyReset();
    chk(!mprActive, "R1 after reset", mprActive, 0);
    for (int k = 0; k < 4; k++) readCheck(2'(k), 0, "R10 defaults restored");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule